// File: doc/BRIEF.md
# DMA Channel Configuration Error Checker

This block sits beside a multi-channel DMA engine and judges whether the descriptor and arbitration settings of the channel being serviced are legal. It watches three engine events and runs a different set of checks on each. When a channel activates, it checks address and offset alignment, iteration counts and, under fixed arbitration, whether priorities are unique. At major loop completion it checks the alignment of the scatter/gather address. At minor loop completion it checks the consistency of the channel link. Bus error strobes from the engine are folded into the same report.

Every detected error sets that channel's bit in a sticky error vector. In the same clock edge, an encoded status word is written. It holds a valid bit, the channel number and one flag per error class. The most recent error overwrites the word. A channel is never disabled by the checker, so an uncorrected channel reports the same error each time it is serviced. Software clears an error bit by pulsing a clear strobe with a channel index. Each channel's interrupt request is its error bit gated by its own enable. All pins are plain control and status signals. There is no streaming interface and no back-pressure.

Top module: `dma_cfg_err_top`

## Requirements
- R1: When `fixed_arb`=1 and any two channels hold equal 4-bit priority values, an activation sets status bit 14. With `fixed_arb`=0, equal priorities raise nothing.
- R2: With `sg_en`=1 and `major_done` pulsed, a `sg_addr` whose low 5 bits are not zero sets status bit 2. A misaligned `sg_addr` seen only at activation raises nothing.
- R3: With `link_en`=1 and `minor_done` pulsed, a mismatch between `citer_elink` and `biter_elink` sets status bit 3.
- R4: At activation, the transfer size is 1<<`xfer_sz` bytes. A source address misaligned to that size sets bit 7, a misaligned source offset sets bit 6, a misaligned destination address sets bit 5, and a misaligned destination offset sets bit 4.
- R5: At activation, an iteration count error sets bit 3. This happens when `citer` is zero, `biter` is zero, or `citer` > `biter`.
- R6: A `src_bus_err` strobe sets bit 1 and a `dst_bus_err` strobe sets bit 0, for channel `act_ch`.
- R7: After reset the status word and the error vector are zero. A report writes bit 31 = 1 and the channel number in bits 11:8, with all other unused bits zero. All flags raised in one cycle appear together, and a later report overwrites the word.
- R8: Any error in cycle t sets `err_vec[act_ch]` and loads the status word at the same clock edge.
- R9: A `clr_strobe` clears `err_vec[clr_ch]` at the next edge. If the same channel reports an error in that same cycle, the bit stays set.
- R10: `err_irq[i]` equals `err_vec[i]` AND `err_irq_en[i]`.
- R11: An erroring channel is not disabled. Servicing it again with the same faulty settings reports the same error again.
- R12: A cycle with no error leaves the status word unchanged. `NCH` is at most 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fixed_arb | input | 1 | 1 = fixed-priority arbitration |
| prio_flat | input | NCH*PRIO_W | Channel priorities, channel i at bits i*PRIO_W |
| act_ch | input | CH_W | Channel currently serviced |
| act_strobe | input | 1 | Channel activation event |
| major_done | input | 1 | Major loop completion event |
| minor_done | input | 1 | Minor loop completion event |
| sg_en | input | 1 | Scatter/gather enabled in descriptor |
| sg_addr | input | ADDR_W | Next descriptor address |
| link_en | input | 1 | Minor loop channel link enabled |
| citer_elink | input | 1 | Link-enable bit of current iteration count |
| biter_elink | input | 1 | Link-enable bit of beginning iteration count |
| citer | input | CNT_W | Current iteration count |
| biter | input | CNT_W | Beginning iteration count |
| xfer_sz | input | 2 | Transfer size code, bytes = 1<<code |
| src_addr | input | ADDR_W | Source address |
| dst_addr | input | ADDR_W | Destination address |
| src_off | input | OFF_W | Source signed offset |
| dst_off | input | OFF_W | Destination signed offset |
| src_bus_err | input | 1 | Source bus error strobe |
| dst_bus_err | input | 1 | Destination bus error strobe |
| clr_strobe | input | 1 | Clear one channel's error bit |
| clr_ch | input | CH_W | Channel to clear |
| err_irq_en | input | NCH | Per-channel error interrupt enable |
| err_vec | output | NCH | Sticky per-channel error bits |
| err_status | output | 32 | Last error status word |
| err_irq | output | NCH | Per-channel error interrupt |

## Verification
Two functions can land in the same cycle on the same channel: clearing an error bit and setting it again. The bench pulses `clr_strobe` for a channel while that channel is activated with a faulty descriptor. The expected result is that the bit survives, since setting wins. A clear that names a different channel must still take effect in that cycle. Several error classes are also raised in one cycle, by activating with a misaligned address while a bus error strobe is high. That case is judged by requiring both flags in one status word.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int ST_VLD   = 31;
  localparam int ST_CPE   = 14;
  localparam int ST_CH_LO = 8;
  localparam int ST_CH_W  = 4;

  typedef struct packed {
    logic cpe;
    logic sae;
    logic soe;
    logic dae;
    logic doe;
    logic nce;
    logic sge;
    logic sbe;
    logic dbe;
  } err_bits_t;

  function automatic logic [31:0] pack_status(input err_bits_t e, input logic [ST_CH_W-1:0] ch);
    logic [31:0] w;
    w = '0;
    w[ST_VLD] = 1'b1;
    w[ST_CPE] = e.cpe;
    w[ST_CH_LO +: ST_CH_W] = ch;
    w[7:0] = {e.sae, e.soe, e.dae, e.doe, e.nce, e.sge, e.sbe, e.dbe};
    return w;
  endfunction
endpackage

// File: rtl/dma_prio_check.sv
module dma_prio_check #(
  parameter int NCH    = 16,
  parameter int PRIO_W = 4
) (
  input  logic [NCH*PRIO_W-1:0] prio_flat,
  input  logic                  fixed_arb,
  output logic                  conflict
);
  localparam int NPAIR = NCH * (NCH - 1) / 2;
  logic [NPAIR-1:0] eq;

  for (genvar i = 0; i < NCH; i++) begin : g_a
    for (genvar j = i + 1; j < NCH; j++) begin : g_b
      localparam int IDX = i * NCH - (i * (i + 1)) / 2 + (j - i - 1);
      assign eq[IDX] = prio_flat[i*PRIO_W +: PRIO_W] == prio_flat[j*PRIO_W +: PRIO_W];
    end
  end

  assign conflict = fixed_arb & (|eq);
endmodule

// File: rtl/dma_desc_check.sv
module dma_desc_check
  import dma_cfg_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int OFF_W        = 16,
  parameter int CNT_W        = 15,
  parameter int SG_ALIGN_LOG = 5
) (
  input  logic              act_strobe,
  input  logic              major_done,
  input  logic              minor_done,
  input  logic              prio_conflict,
  input  logic              sg_en,
  input  logic [ADDR_W-1:0] sg_addr,
  input  logic              link_en,
  input  logic              citer_elink,
  input  logic              biter_elink,
  input  logic [CNT_W-1:0]  citer,
  input  logic [CNT_W-1:0]  biter,
  input  logic [1:0]        xfer_sz,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic              src_bus_err,
  input  logic              dst_bus_err,
  output err_bits_t         bits,
  output logic              hit
);
  logic [3:0] sz_mask;
  logic       cnt_bad, link_bad;

  always_comb begin
    sz_mask  = (4'd1 << xfer_sz) - 4'd1;
    cnt_bad  = (citer == '0) || (biter == '0) || (citer > biter);
    link_bad = minor_done && link_en && (citer_elink != biter_elink);

    bits.cpe = act_strobe && prio_conflict;
    bits.sae = act_strobe && ((src_addr[3:0] & sz_mask) != 4'd0);
    bits.soe = act_strobe && ((src_off[3:0]  & sz_mask) != 4'd0);
    bits.dae = act_strobe && ((dst_addr[3:0] & sz_mask) != 4'd0);
    bits.doe = act_strobe && ((dst_off[3:0]  & sz_mask) != 4'd0);
    bits.nce = (act_strobe && cnt_bad) || link_bad;
    bits.sge = major_done && sg_en && (sg_addr[SG_ALIGN_LOG-1:0] != '0);
    bits.sbe = src_bus_err;
    bits.dbe = dst_bus_err;
    hit      = |bits;
  end
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_cfg_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  err_bits_t       bits,
  input  logic            hit,
  input  logic [CH_W-1:0] act_ch,
  input  logic            clr_strobe,
  input  logic [CH_W-1:0] clr_ch,
  output logic [NCH-1:0]  err_vec,
  output logic [31:0]     err_status
);
  logic [ST_CH_W-1:0] ch_field;
  assign ch_field = ST_CH_W'(act_ch);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        err_vec[i] <= 1'b0;
      else if (hit && act_ch == CH_W'(i))
        err_vec[i] <= 1'b1;
      else if (clr_strobe && clr_ch == CH_W'(i))
        err_vec[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_status <= '0;
    else if (hit) err_status <= pack_status(bits, ch_field);
  end
endmodule

// File: rtl/dma_cfg_err_top.sv
module dma_cfg_err_top
  import dma_cfg_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int CNT_W  = 15,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fixed_arb,
  input  logic [NCH*PRIO_W-1:0] prio_flat,
  input  logic [CH_W-1:0]       act_ch,
  input  logic                  act_strobe,
  input  logic                  major_done,
  input  logic                  minor_done,
  input  logic                  sg_en,
  input  logic [ADDR_W-1:0]     sg_addr,
  input  logic                  link_en,
  input  logic                  citer_elink,
  input  logic                  biter_elink,
  input  logic [CNT_W-1:0]      citer,
  input  logic [CNT_W-1:0]      biter,
  input  logic [1:0]            xfer_sz,
  input  logic [ADDR_W-1:0]     src_addr,
  input  logic [ADDR_W-1:0]     dst_addr,
  input  logic [OFF_W-1:0]      src_off,
  input  logic [OFF_W-1:0]      dst_off,
  input  logic                  src_bus_err,
  input  logic                  dst_bus_err,
  input  logic                  clr_strobe,
  input  logic [CH_W-1:0]       clr_ch,
  input  logic [NCH-1:0]        err_irq_en,
  output logic [NCH-1:0]        err_vec,
  output logic [31:0]           err_status,
  output logic [NCH-1:0]        err_irq
);
  logic      prio_conflict;
  err_bits_t bits;
  logic      hit;

  dma_prio_check #(.NCH(NCH), .PRIO_W(PRIO_W)) u_prio (
    .prio_flat(prio_flat), .fixed_arb(fixed_arb), .conflict(prio_conflict)
  );

  dma_desc_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .SG_ALIGN_LOG(5)) u_desc (
    .act_strobe(act_strobe), .major_done(major_done), .minor_done(minor_done),
    .prio_conflict(prio_conflict), .sg_en(sg_en), .sg_addr(sg_addr),
    .link_en(link_en), .citer_elink(citer_elink), .biter_elink(biter_elink),
    .citer(citer), .biter(biter), .xfer_sz(xfer_sz),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_off(src_off), .dst_off(dst_off),
    .src_bus_err(src_bus_err), .dst_bus_err(dst_bus_err),
    .bits(bits), .hit(hit)
  );

  dma_err_capture #(.NCH(NCH), .CH_W(CH_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .bits(bits), .hit(hit), .act_ch(act_ch),
    .clr_strobe(clr_strobe), .clr_ch(clr_ch),
    .err_vec(err_vec), .err_status(err_status)
  );

  assign err_irq = err_vec & err_irq_en;
endmodule

// File: rtl/dma_cfg_err_chk.sv
module dma_cfg_err_chk #(
  parameter int NCH  = 16,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fixed_arb,
  input logic            hit,
  input logic [CH_W-1:0] act_ch,
  input logic            clr_strobe,
  input logic [CH_W-1:0] clr_ch,
  input logic [NCH-1:0]  err_vec,
  input logic [31:0]     err_status
);
  assert_set_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (err_vec[$past(act_ch)] && err_status[31]));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_strobe && !(hit && act_ch == clr_ch)) |=> !err_vec[$past(clr_ch)]);

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status[30:15] == '0) && (err_status[13:12] == '0));

  assert_hold_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(err_status));

  assert_prio_fixed_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_status[14]) |-> $past(fixed_arb));
endmodule

bind dma_cfg_err_top dma_cfg_err_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fixed_arb(fixed_arb), .hit(hit), .act_ch(act_ch),
  .clr_strobe(clr_strobe), .clr_ch(clr_ch), .err_vec(err_vec), .err_status(err_status)
);

// File: tb/test_dma_cfg_err_top.sv
module test_dma_cfg_err_top;
  localparam int NCH = 16;
  localparam int CH_W = 4;

  logic clk = 0, rst_n = 0;
  logic fixed_arb;
  logic [63:0] prio_flat;
  logic [CH_W-1:0] act_ch, clr_ch;
  logic act_strobe, major_done, minor_done, sg_en, link_en, citer_elink, biter_elink;
  logic [31:0] sg_addr, src_addr, dst_addr;
  logic [14:0] citer, biter;
  logic [1:0] xfer_sz;
  logic [15:0] src_off, dst_off;
  logic src_bus_err, dst_bus_err, clr_strobe;
  logic [NCH-1:0] err_irq_en, err_vec, err_irq;
  logic [31:0] err_status;

  int checks = 0, errors = 0;
  logic [NCH-1:0] m_vec;
  logic [31:0] m_stat;
  typedef struct { logic [NCH-1:0] vec; logic [31:0] stat; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  dma_cfg_err_top i_dma_cfg_err_top (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    act_strobe = 0; major_done = 0; minor_done = 0; src_bus_err = 0; dst_bus_err = 0;
    clr_strobe = 0; clr_ch = 0;
  endtask

  task automatic good_desc();
    sg_en = 0; sg_addr = 32'h100; link_en = 0; citer_elink = 0; biter_elink = 0;
    citer = 15'd4; biter = 15'd4; xfer_sz = 2'd2; src_addr = 32'h1000; dst_addr = 32'h2000;
    src_off = 16'd4; dst_off = 16'd4;
  endtask

  // Driver: inputs already set at negedge; compute expected from requirements and push.
  task automatic go(string tag);
    logic [3:0] m;
    logic dup, cpe, sae, soe, dae, doe, nce, sge, any;
    m = (4'd1 << xfer_sz) - 4'd1;
    dup = 0;
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (prio_flat[i*4 +: 4] == prio_flat[j*4 +: 4]) dup = 1;
    cpe = act_strobe && fixed_arb && dup;
    sae = act_strobe && (src_addr[3:0] & m) != 0;
    soe = act_strobe && (src_off[3:0] & m) != 0;
    dae = act_strobe && (dst_addr[3:0] & m) != 0;
    doe = act_strobe && (dst_off[3:0] & m) != 0;
    nce = (act_strobe && (citer == 0 || biter == 0 || citer > biter)) ||
          (minor_done && link_en && citer_elink != biter_elink);
    sge = major_done && sg_en && sg_addr[4:0] != 0;
    any = cpe | sae | soe | dae | doe | nce | sge | src_bus_err | dst_bus_err;
    if (clr_strobe) m_vec[clr_ch] = 1'b0;
    if (any) begin
      m_vec[act_ch] = 1'b1;
      m_stat = 32'h8000_0000 | ({31'b0, cpe} << 14) | ({28'b0, act_ch} << 8) |
               {24'b0, sae, soe, dae, doe, nce, sge, src_bus_err, dst_bus_err};
    end
    q.push_back('{m_vec, m_stat, tag});
    @(negedge clk);
    idle_inputs();
  endtask

  // Monitor: after each edge pop the expected item and compare
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " vec"}, 64'(err_vec), 64'(e.vec));
        chk({e.tag, " status"}, 64'(err_status), 64'(e.stat));
        chk({e.tag, " irq R10"}, 64'(err_irq), 64'(e.vec & err_irq_en));
      end
    end
  end

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs(); good_desc();
    fixed_arb = 1; act_ch = 0; err_irq_en = 16'h00FF;
    for (int i = 0; i < NCH; i++) prio_flat[i*4 +: 4] = 4'(i);
    m_vec = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    chk("reset R7 status", 64'(err_status), 0);
    chk("reset R7 vec", 64'(err_vec), 0);
    rst_n = 1;
    @(negedge clk);

    act_ch = 1; act_strobe = 1; go("clean activation R12");
    act_ch = 2; act_strobe = 1; src_addr = 32'h1001; go("src addr R4");
    src_addr = 32'h1000; act_ch = 3; act_strobe = 1; src_off = 16'd2; go("src off R4");
    src_off = 16'd4; act_ch = 4; act_strobe = 1; dst_addr = 32'h2002; dst_off = 16'd6; go("dst R4");
    good_desc(); act_ch = 5; act_strobe = 1; xfer_sz = 0; src_addr = 32'h1003; go("byte size ok R4");
    good_desc(); act_ch = 6; act_strobe = 1; citer = 5; go("citer>biter R5");
    citer = 0; act_ch = 6; act_strobe = 1; go("citer zero R5");
    good_desc(); prio_flat[7*4 +: 4] = 4'd3;
    act_ch = 7; act_strobe = 1; go("prio dup fixed R1");
    fixed_arb = 0; act_ch = 8; act_strobe = 1; go("prio dup rr R1");
    fixed_arb = 1; prio_flat[7*4 +: 4] = 4'd7;
    sg_en = 1; sg_addr = 32'h110; act_ch = 9; act_strobe = 1; go("sg at activation R2");
    major_done = 1; act_ch = 9; go("sg misaligned R2");
    sg_addr = 32'h120; major_done = 1; act_ch = 10; go("sg aligned R2");
    good_desc(); link_en = 1; citer_elink = 1; minor_done = 1; act_ch = 11; go("link mismatch R3");
    biter_elink = 1; minor_done = 1; act_ch = 12; go("link match R3");
    good_desc(); src_bus_err = 1; act_ch = 13; go("src bus R6");
    dst_bus_err = 1; act_ch = 14; act_strobe = 1; src_addr = 32'h1002; go("multi flag R6 R7");
    good_desc(); clr_strobe = 1; clr_ch = 2; go("clear R9");
    clr_strobe = 1; clr_ch = 3; act_ch = 3; act_strobe = 1; src_off = 16'd1; go("clear vs set R9");
    clr_strobe = 1; clr_ch = 4; act_ch = 3; act_strobe = 1; go("repeat error R11");
    good_desc(); err_irq_en = 16'hFFFF; act_ch = 15; act_strobe = 1; go("irq enable R10");
    repeat (3) @(negedge clk);
    chk("final status R12", 64'(err_status), 64'(m_stat));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule